// File: doc/BRIEF.md
# Endian-Aware Bus Width Matcher

This block adapts a 36-bit long-word queue to an external port that can be 36, 18 or 9 bits wide. Toward the queue it gathers two 18-bit words or four 9-bit bytes from the port into one long word. It hands that long word over only when the long word is complete. Away from the queue it takes one long word and returns it to the port one word or one byte at a time. Each 9-bit lane carries one byte, and a word is two adjacent lanes.

Three selects set the port width and the piece order: first the most significant piece or first the least significant piece. The selects are captured while the synchronous active-low reset is asserted and are ignored after it. Every side uses a valid/ready handshake. The write-side full flag and the read-side empty flag only move on long-word boundaries.

A partially gathered long word and the piece positions are cleared by reset. The queue storage and any clock crossing sit outside this block.

Top module: `bus_matcher`

## Requirements
- R1: Width decode: `cfg_narrow`=0 gives long-word mode, with one 36-bit piece per long word. `cfg_narrow`=1 with `cfg_byte`=0 gives word mode, with two 18-bit pieces. `cfg_narrow`=1 with `cfg_byte`=1 gives byte mode, with four 9-bit pieces. Narrow pieces travel on the low bits of the port buses, and the unused upper bits of `wr_data` are ignored.
- R2: Write ordering: the k-th piece written (k from 0) lands in group g of the long word, with groups counted from the least significant end. g = k when `cfg_lsb_first`=1, and g = n-1-k otherwise, where n is the piece count. Group g of width P occupies bits [g*P+P-1 : g*P].
- R3: Read ordering: the k-th piece read is group g of the popped long word, with the same mapping as R2. It appears on the low P bits of `rd_data`, and all bits above P are zero.
- R4: `push_valid` rises only on the edge that accepts the last piece of a long word. While `push_valid` is high and `push_ready` is low, `push_data` holds its value.
- R5: `wr_full` is high exactly while a gathered long word waits for the queue. It rises only on the edge that accepts the last piece.
- R6: `wr_ready` is high whenever the next piece is not the last one. At the last piece, it is low only while a gathered long word is still waiting and `push_ready` is low.
- R7: `rd_empty` stays low for all the pieces of a long word. It rises only on the edge that reads the last piece when no new long word is popped on that edge. `pop_ready` is high only when the block holds no long word or the last piece is being read.
- R8: Reset discards a partly gathered long word and returns the piece position to zero, so the first piece after reset is treated as piece 0.
- R9: Changes on `cfg_narrow`, `cfg_byte` and `cfg_lsb_first` while reset is deasserted have no effect on width or order.
- R10: After reset the outputs are in their idle state: `wr_ready`=1, `wr_full`=0, `push_valid`=0, `pop_ready`=1, `rd_valid`=0 and `rd_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the width and order selects |
| cfg_narrow | input | 1 | 1 selects a narrow port (word or byte) |
| cfg_byte | input | 1 | In narrow mode, 1 selects byte width and 0 selects word width |
| cfg_lsb_first | input | 1 | 1 sends the least significant piece first |
| wr_valid | input | 1 | Port write piece valid |
| wr_ready | output | 1 | Port write piece accepted |
| wr_data | input | 36 | Port write piece, on the low bits in narrow modes |
| wr_full | output | 1 | Gathered long word waiting for the queue |
| push_valid | output | 1 | Long word offered to the queue |
| push_ready | input | 1 | Queue accepts the long word |
| push_data | output | 36 | Gathered long word |
| pop_valid | input | 1 | Queue offers a long word |
| pop_ready | output | 1 | Block takes the offered long word |
| pop_data | input | 36 | Long word from the queue |
| rd_valid | output | 1 | Port read piece valid |
| rd_ready | input | 1 | Port consumes the piece |
| rd_data | output | 36 | Port read piece, zero-extended |
| rd_empty | output | 1 | No long word held for the port |

## Verification
On every cycle, the assertions check the handshake rules and flag timing:
- `push_valid`, `wr_full` and `rd_empty` only change at the last piece of a long word;
- a waiting long word stays stable;
- a long word is never popped in the middle of another;
- the upper bits of narrow reads are zero;
- the captured mode holds steady outside reset.

Only the bench scenarios can show the piece ordering itself. The bench streams random long words through all six width and order combinations and compares each gathered long word and each split piece with values it computes arithmetically. It also covers reset in the middle of a long word and select changes after reset.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

   localparam int unsigned LANES = 4;

   typedef enum logic [1:0] {
      BW_LONG = 2'd0,
      BW_WORD = 2'd1,
      BW_BYTE = 2'd2
   } bw_mode_e;

   // index of the final piece inside a long word
   function automatic logic [1:0] last_pos(bw_mode_e m);
      case (m)
         BW_WORD: return 2'd1;
         BW_BYTE: return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   // does assembly lane `lane` take data when group `grp` is written
   function automatic logic lane_hit(bw_mode_e m, logic [1:0] grp, logic [1:0] lane);
      case (m)
         BW_WORD: return lane[1] == grp[0];
         BW_BYTE: return lane == grp;
         default: return 1'b1;
      endcase
   endfunction

   // port lane feeding assembly lane `lane`
   function automatic logic [1:0] wr_src(bw_mode_e m, logic [1:0] lane);
      case (m)
         BW_WORD: return {1'b0, lane[0]};
         BW_BYTE: return 2'd0;
         default: return lane;
      endcase
   endfunction

   // held lane driving port lane `j` when group `grp` is read
   function automatic logic [1:0] rd_src(bw_mode_e m, logic [1:0] grp, logic [1:0] j);
      case (m)
         BW_WORD: return {grp[0], j[0]};
         BW_BYTE: return grp;
         default: return j;
      endcase
   endfunction

   // port lane `j` carries data in this mode
   function automatic logic rd_used(bw_mode_e m, logic [1:0] j);
      case (m)
         BW_WORD: return ~j[1];
         BW_BYTE: return j == 2'd0;
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/bwm_cfg.sv
module bwm_cfg
   import bwm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_narrow,
   input  logic     sel_byte,
   input  logic     sel_lsb_first,
   output bw_mode_e mode,
   output logic     lsb_first,
   output logic [1:0] last_idx
);

   // selects are sampled only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (!sel_narrow)   mode <= BW_LONG;
         else if (sel_byte) mode <= BW_BYTE;
         else               mode <= BW_WORD;
         lsb_first <= sel_lsb_first;
      end
   end

   assign last_idx = last_pos(mode);

endmodule

// File: rtl/bwm_pack.sv
module bwm_pack
   import bwm_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   localparam int unsigned LONG_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bw_mode_e          mode,
   input  logic              lsb_first,
   input  logic [1:0]        last_idx,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [LONG_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [LONG_W-1:0] out_data,
   output logic              at_last
);

   logic [1:0] pos_q;
   logic [1:0] grp;
   logic       accept;
   logic       held_q;
   logic [LANES-1:0][LANE_W-1:0] in_l, asm_q, merged, out_q;

   assign in_l     = in_data;
   assign at_last  = (pos_q == last_idx);
   assign grp      = lsb_first ? pos_q : (last_idx - pos_q);
   assign in_ready = !at_last || !held_q || out_ready;
   assign accept   = in_valid && in_ready;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i] = lane_hit(mode, grp, 2'(i)) ? in_l[wr_src(mode, 2'(i))]
                                                    : asm_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= 2'd0;
         asm_q  <= '0;
         out_q  <= '0;
         held_q <= 1'b0;
      end else begin
         if (accept) begin
            asm_q <= merged;
            pos_q <= at_last ? 2'd0 : pos_q + 2'd1;
         end
         if (accept && at_last) begin
            out_q  <= merged;
            held_q <= 1'b1;
         end else if (out_ready) begin
            held_q <= 1'b0;
         end
      end
   end

   assign out_valid = held_q;
   assign out_data  = out_q;

endmodule

// File: rtl/bwm_unpack.sv
module bwm_unpack
   import bwm_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   localparam int unsigned LONG_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bw_mode_e          mode,
   input  logic              lsb_first,
   input  logic [1:0]        last_idx,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [LONG_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [LONG_W-1:0] out_data,
   output logic              at_last
);

   logic [1:0] pos_q;
   logic [1:0] grp;
   logic       hold_v;
   logic       take, load;
   logic [LANES-1:0][LANE_W-1:0] hold_q, out_l;

   assign at_last  = (pos_q == last_idx);
   assign grp      = lsb_first ? pos_q : (last_idx - pos_q);
   assign take     = hold_v && out_ready;
   assign in_ready = !hold_v || (out_ready && at_last);
   assign load     = in_valid && in_ready;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign out_l[j] = rd_used(mode, 2'(j)) ? hold_q[rd_src(mode, grp, 2'(j))]
                                             : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= 2'd0;
         hold_q <= '0;
         hold_v <= 1'b0;
      end else begin
         if (take) pos_q <= at_last ? 2'd0 : pos_q + 2'd1;
         if (load) begin
            hold_q <= in_data;
            hold_v <= 1'b1;
         end else if (take && at_last) begin
            hold_v <= 1'b0;
         end
      end
   end

   assign out_valid = hold_v;
   assign out_data  = out_l;

endmodule

// File: rtl/bus_matcher.sv
module bus_matcher
   import bwm_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   localparam int unsigned LONG_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_narrow,
   input  logic              cfg_byte,
   input  logic              cfg_lsb_first,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [LONG_W-1:0] wr_data,
   output logic              wr_full,
   output logic              push_valid,
   input  logic              push_ready,
   output logic [LONG_W-1:0] push_data,
   input  logic              pop_valid,
   output logic              pop_ready,
   input  logic [LONG_W-1:0] pop_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [LONG_W-1:0] rd_data,
   output logic              rd_empty
);

   if (LANE_W < 1) begin : g_bad_lane
      $error("bus_matcher: LANE_W must be at least 1");
   end

   bw_mode_e   mode;
   logic       lsb_first;
   logic [1:0] last_idx;
   logic       wr_at_last, rd_at_last;

   bwm_cfg u_cfg (
      .clk(clk), .rst_n(rst_n),
      .sel_narrow(cfg_narrow), .sel_byte(cfg_byte), .sel_lsb_first(cfg_lsb_first),
      .mode(mode), .lsb_first(lsb_first), .last_idx(last_idx)
   );

   bwm_pack #(.LANE_W(LANE_W)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .mode(mode), .lsb_first(lsb_first), .last_idx(last_idx),
      .in_valid(wr_valid), .in_ready(wr_ready), .in_data(wr_data),
      .out_valid(push_valid), .out_ready(push_ready), .out_data(push_data),
      .at_last(wr_at_last)
   );

   bwm_unpack #(.LANE_W(LANE_W)) u_unpack (
      .clk(clk), .rst_n(rst_n),
      .mode(mode), .lsb_first(lsb_first), .last_idx(last_idx),
      .in_valid(pop_valid), .in_ready(pop_ready), .in_data(pop_data),
      .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data),
      .at_last(rd_at_last)
   );

   assign wr_full  = push_valid;
   assign rd_empty = !rd_valid;

endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
   parameter int unsigned LANE_W = 9,
   localparam int unsigned LONG_W = LANE_W * 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              wr_at_last,
   input logic              wr_full,
   input logic              push_valid,
   input logic              push_ready,
   input logic [LONG_W-1:0] push_data,
   input logic              pop_ready,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic              rd_at_last,
   input logic              rd_empty,
   input logic [LONG_W-1:0] rd_data
);

   AST_PUSH_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(push_valid) |-> $past(wr_valid && wr_ready && wr_at_last)); // R4

   AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_ready |=> push_valid && $stable(push_data)); // R4

   AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_full) |-> $past(wr_valid && wr_ready && wr_at_last)); // R5

   AST_MID_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_at_last |-> wr_ready); // R6

   AST_EMPTY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_empty) |-> $past(rd_valid && rd_ready && rd_at_last)); // R7

   AST_NO_MIDLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_at_last |-> !pop_ready); // R7

   AST_UPPER_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && mode == 2'd1 |-> rd_data[LONG_W-1:2*LANE_W] == '0); // R3

   AST_UPPER_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && mode == 2'd2 |-> rd_data[LONG_W-1:LANE_W] == '0); // R3

   AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode)); // R9

endmodule

bind bus_matcher bwm_chk #(.LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_at_last(wr_at_last), .wr_full(wr_full),
   .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
   .pop_ready(pop_ready),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_at_last(rd_at_last),
   .rd_empty(rd_empty), .rd_data(rd_data)
);

// File: tb/sim_bus_matcher.sv
module sim_bus_matcher;

   localparam int NW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_lsb_first = 1'b0;
   logic        wr_valid = 1'b0, push_ready = 1'b0, pop_valid = 1'b0, rd_ready = 1'b0;
   logic [35:0] wr_data = '0, pop_data = '0;
   logic        wr_ready, wr_full, push_valid, pop_ready, rd_valid, rd_empty;
   logic [35:0] push_data, rd_data;

   int n_chk = 0, n_fail = 0;
   int np = 1;
   bit lsb_cfg = 1'b0;

   always #4 clk = ~clk;

   bus_matcher u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte), .cfg_lsb_first(cfg_lsb_first),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_full(wr_full),
      .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
      .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_empty(rd_empty)
   );

   task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [35:0] rnd36();
      return {4'($urandom), 32'($urandom)};
   endfunction

   function automatic logic [35:0] pmask();
      int pw = 36 / np;
      return (pw == 36) ? '1 : ((36'd1 << pw) - 36'd1);
   endfunction

   // k-th transferred piece of long word w, zero-extended
   function automatic logic [35:0] piece(logic [35:0] w, int k);
      int g  = lsb_cfg ? k : np - 1 - k;
      int pw = 36 / np;
      return (w >> (g * pw)) & pmask();
   endfunction

   task automatic do_reset(bit nar, bit bs, bit ls);
      @(negedge clk);
      cfg_narrow = nar; cfg_byte = bs; cfg_lsb_first = ls;
      rst_n = 1'b0;
      wr_valid = 0; push_ready = 0; pop_valid = 0; rd_ready = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: flip the selects after reset; behaviour must not follow
      cfg_narrow = ~nar; cfg_byte = ~bs; cfg_lsb_first = ~ls;
      // R10 idle state
      check(wr_ready == 1'b1,   "R10 wr_ready",   36'(wr_ready),   36'd1);
      check(wr_full == 1'b0,    "R10 wr_full",    36'(wr_full),    36'd0);
      check(push_valid == 1'b0, "R10 push_valid", 36'(push_valid), 36'd0);
      check(pop_ready == 1'b1,  "R10 pop_ready",  36'(pop_ready),  36'd1);
      check(rd_valid == 1'b0,   "R10 rd_valid",   36'(rd_valid),   36'd0);
      check(rd_empty == 1'b1,   "R10 rd_empty",   36'(rd_empty),   36'd1);
   endtask

   task automatic write_stream();
      logic [35:0] prev = '0;
      bit pend = 1'b0;
      for (int w = 0; w < NW; w++) begin
         logic [35:0] lw = rnd36();
         for (int k = 0; k < np; k++) begin
            wr_valid   = 1'b1;
            wr_data    = (rnd36() & ~pmask()) | piece(lw, k);   // R1: junk above piece
            push_ready = 1'b0;
            #1;
            if (k == np - 1 && pend) begin
               check(wr_ready == 1'b0, "R6 blocked at last", 36'(wr_ready), 36'd0);
               check(push_data == prev, "R4 held word", push_data, prev);
               push_ready = 1'b1;
               #1;
               check(wr_ready == 1'b1, "R6 freed by push_ready", 36'(wr_ready), 36'd1);
            end else begin
               check(wr_ready == 1'b1, "R6 piece accepted", 36'(wr_ready), 36'd1);
            end
            @(negedge clk);
            wr_valid = 1'b0; push_ready = 1'b0;
            if (k < np - 1) begin
               check(push_valid == pend, "R4 no partial push", 36'(push_valid), 36'(pend));
               check(wr_full == pend, "R5 full mid word", 36'(wr_full), 36'(pend));
               if (pend) check(push_data == prev, "R4 stable", push_data, prev);
            end else begin
               check(push_valid == 1'b1, "R1 piece count", 36'(push_valid), 36'd1);
               check(wr_full == 1'b1, "R5 full at last", 36'(wr_full), 36'd1);
               check(push_data == lw, "R2 write order", push_data, lw);
               if (w == 0) check(push_data == lw, "R8 first word after reset", push_data, lw);
               pend = 1'b1;
               prev = lw;
            end
         end
      end
      push_ready = 1'b1;
      #1;
      check(push_data == prev, "R4 last word", push_data, prev);
      @(negedge clk);
      push_ready = 1'b0;
      check(push_valid == 1'b0, "R4 drained", 36'(push_valid), 36'd0);
      check(wr_full == 1'b0, "R5 drained", 36'(wr_full), 36'd0);
   endtask

   task automatic read_stream();
      logic [35:0] cur = rnd36();
      pop_valid = 1'b1; pop_data = cur;
      #1;
      check(pop_ready == 1'b1, "R7 pop when empty", 36'(pop_ready), 36'd1);
      @(negedge clk);
      pop_valid = 1'b0;
      for (int w = 0; w < NW; w++) begin
         logic [35:0] nxt = rnd36();
         for (int k = 0; k < np; k++) begin
            check(rd_empty == 1'b0, "R7 empty low", 36'(rd_empty), 36'd0);
            check(rd_data == piece(cur, k), "R3 read order", rd_data, piece(cur, k));
            if (w < NW - 1) begin
               pop_valid = 1'b1; pop_data = nxt;
            end
            rd_ready = 1'b1;
            #1;
            check(pop_ready == (k == np - 1), "R7 pop timing", 36'(pop_ready), 36'(k == np - 1));
            @(negedge clk);
            rd_ready = 1'b0; pop_valid = 1'b0;
         end
         if (w == NW - 1)
            check(rd_empty == 1'b1, "R7 empty after last", 36'(rd_empty), 36'd1);
         cur = nxt;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int c = 0; c < 6; c++) begin
         bit nar = (c >= 2);
         bit bs  = (c >= 4);
         bit ls  = c[0];
         np      = !nar ? 1 : (bs ? 4 : 2);
         lsb_cfg = ls;
         do_reset(nar, bs, ls);
         if (np > 1) begin
            // R8: leave a partial long word, then reset
            wr_valid = 1'b1; wr_data = '1;
            @(negedge clk);
            wr_valid = 1'b0;
            check(push_valid == 1'b0, "R4 partial not pushed", 36'(push_valid), 36'd0);
            do_reset(nar, bs, ls);
         end
         write_stream();
         read_stream();
      end
      summary();
      $finish;
   end

endmodule